// File: doc/BRIEF.md
# Exponential Brightness Fade Engine

This block sits between the source of a dimming duty (a measured input duty or a value written by software) and the PWM generator. With fading off, it forwards every new target duty on the next clock. With fading on, it moves the applied duty toward the target in multiplicative steps. Each update scales the present duty up or down by a fixed fraction, and the update rate is divided down from a once-per-dimming-period strobe. A change in brightness therefore looks smooth on a logarithmic scale in both directions.

Duty is an unsigned 18-bit fraction. Zero means off and all ones (262143) means 100 %. A gain select chooses the step fraction (1/16 or 1/8). A rate field chooses how many dimming periods pass between updates. When a fade heads toward 100 %, the target must stay unchanged until the applied duty has reached it.

Top module: `fade_engine`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `duty_out` is 0.
- R2: When `fade_en` is low, `duty_out` equals the `target_duty` sampled on the previous clock edge, and the period divider restarts from zero.
- R3: With `fade_en` high, `duty_out` changes only at an edge where `period_tick` is high and the update interval has elapsed. The interval is 2^`rate_sel` ticks, so value 0 gives an update on every tick.
- R4: On an upward update, the step is the present duty shifted right by 4 when `gain_sel`=0, or by 3 when `gain_sel`=1. The step is added to the present duty.
- R5: On a downward update, the same step (same shift rule as R4) is subtracted from the present duty.
- R6: An update never carries `duty_out` past `target_duty`. When the step would overshoot, `duty_out` becomes exactly the target.
- R7: A step computed as 0 is raised to 1 LSB, so a fade that starts from 0 moves to 1 on its first update.
- R8: `rate_sel` values 6 and 7 behave as 5, which means 32 ticks per update.
- R9: An upward fade toward 262143 reaches it without wrapping and then holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fade_en | input | 1 | 1: fade toward the target; 0: forward the target directly |
| gain_sel | input | 1 | Step fraction: 0 = 1/16, 1 = 1/8 |
| rate_sel | input | 3 | Update once every 2^value dimming periods (6 and 7 act as 5) |
| period_tick | input | 1 | One-cycle strobe, once per dimming period |
| target_duty | input | 18 | Requested duty fraction |
| duty_out | output | 18 | Applied duty fraction |

## Verification
The assertions assume that `period_tick` is a single-cycle pulse and that `target_duty` is held for the whole of a fade. Under that assumption, the monotonic-direction and no-overshoot properties compare each new duty against the target of the previous cycle. The bench changes the target only when it reloads the duty with fading off, or at the single edge that starts a fade. Between those points, it issues ticks one at a time with idle cycles in between, and it holds the gain and rate fields constant.

// File: rtl/fade_pkg.sv
package fade_pkg;

    // Default datapath and divider geometry.
    localparam int DUTY_W   = 18;
    localparam int RATE_W   = 3;
    localparam int MAX_RATE = 5;

    // Shift amounts for the two step fractions.
    localparam int SH_FINE   = 4;   // 1/16
    localparam int SH_COARSE = 3;   // 1/8

    typedef enum logic {
        GAIN_FINE   = 1'b0,
        GAIN_COARSE = 1'b1
    } gain_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    typedef struct packed {
        logic  en;
        gain_e gain;
        logic [RATE_W-1:0] rate;
    } fade_cfg_t;

    // Limit a rate code to the largest supported exponent.
    function automatic logic [RATE_W-1:0] clamp_rate(input logic [RATE_W-1:0] code);
        if (int'(code) > MAX_RATE)
            return RATE_W'(MAX_RATE);
        return code;
    endfunction

endpackage

// File: rtl/fade_rate_div.sv
module fade_rate_div
    import fade_pkg::*;
#(
    parameter int RATE_BITS = RATE_W,
    parameter int RATE_MAX  = MAX_RATE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 tick,
    input  logic [RATE_BITS-1:0] rate,
    output logic                 fire
);

    localparam int CNT_W = (RATE_MAX > 0) ? RATE_MAX : 1;

    generate
        if (RATE_MAX == 0) begin : g_every_tick
            assign fire = en & tick;
        end else begin : g_counted
            logic [CNT_W-1:0]   cnt_q;
            logic [RATE_BITS-1:0] eff_rate;
            logic [CNT_W:0]     period_len;
            logic [CNT_W:0]     cnt_next;

            always_comb begin
                if (int'(rate) > RATE_MAX)
                    eff_rate = RATE_BITS'(RATE_MAX);
                else
                    eff_rate = rate;
                period_len = (CNT_W+1)'(1) << eff_rate;
                cnt_next   = {1'b0, cnt_q} + (CNT_W+1)'(1);
            end

            assign fire = en & tick & (cnt_next >= period_len);

            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    cnt_q <= '0;
                end else if (tick) begin
                    if (fire)
                        cnt_q <= '0;
                    else
                        cnt_q <= cnt_next[CNT_W-1:0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fade_stepper.sv
module fade_stepper
    import fade_pkg::*;
#(
    parameter int W         = DUTY_W,
    parameter int SHIFT_LO  = SH_FINE,
    parameter int SHIFT_HI  = SH_COARSE
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] tgt,
    input  gain_e        gain,
    output logic [W-1:0] nxt
);

    logic [W-1:0] delta;
    logic [W:0]   up_sum;
    logic [W-1:0] dn_diff;
    dir_e         dir;

    always_comb begin
        if (cur < tgt)
            dir = DIR_UP;
        else if (cur > tgt)
            dir = DIR_DOWN;
        else
            dir = DIR_HOLD;

        delta = (gain == GAIN_COARSE) ? (cur >> SHIFT_HI) : (cur >> SHIFT_LO);
        if (delta == '0)
            delta = W'(1);

        up_sum  = {1'b0, cur} + {1'b0, delta};
        // Downward moves only happen with cur > tgt >= 0, so delta <= cur.
        dn_diff = cur - delta;

        unique case (dir)
            DIR_UP:   nxt = (up_sum > {1'b0, tgt}) ? tgt : up_sum[W-1:0];
            DIR_DOWN: nxt = (dn_diff < tgt) ? tgt : dn_diff;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/fade_engine.sv
module fade_engine
    import fade_pkg::*;
#(
    parameter int DUTY_BITS = DUTY_W,
    parameter int RATE_BITS = RATE_W,
    parameter int RATE_MAX  = MAX_RATE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fade_en,
    input  logic                 gain_sel,
    input  logic [RATE_BITS-1:0] rate_sel,
    input  logic                 period_tick,
    input  logic [DUTY_BITS-1:0] target_duty,
    output logic [DUTY_BITS-1:0] duty_out
);

    logic                 upd;
    logic [DUTY_BITS-1:0] duty_q;
    logic [DUTY_BITS-1:0] duty_nxt;
    gain_e                gain;

    assign gain = gain_e'(gain_sel);

    fade_rate_div #(
        .RATE_BITS (RATE_BITS),
        .RATE_MAX  (RATE_MAX)
    ) rate_i (
        .clk  (clk),
        .rst  (rst),
        .en   (fade_en),
        .tick (period_tick),
        .rate (rate_sel),
        .fire (upd)
    );

    fade_stepper #(
        .W        (DUTY_BITS),
        .SHIFT_LO (SH_FINE),
        .SHIFT_HI (SH_COARSE)
    ) step_i (
        .cur  (duty_q),
        .tgt  (target_duty),
        .gain (gain),
        .nxt  (duty_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            duty_q <= '0;
        else if (!fade_en)
            duty_q <= target_duty;
        else if (upd)
            duty_q <= duty_nxt;
    end

    assign duty_out = duty_q;

endmodule

// File: rtl/fade_engine_chk.sv
module fade_engine_chk
    import fade_pkg::*;
#(
    parameter int DUTY_BITS = DUTY_W,
    parameter int RATE_BITS = RATE_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 fade_en,
    input logic                 gain_sel,
    input logic [RATE_BITS-1:0] rate_sel,
    input logic                 period_tick,
    input logic [DUTY_BITS-1:0] target_duty,
    input logic [DUTY_BITS-1:0] duty_out
);

    // Largest legal move from the present duty under the current gain.
    logic [DUTY_BITS:0] step_cap;
    assign step_cap = ({1'b0, duty_out} >> (gain_sel ? SH_COARSE : SH_FINE)) + (DUTY_BITS+1)'(1);

    // R1: duty is zero right after reset
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> duty_out == '0);

    // R2: pass-through when fading is off
    p_pass_through_r2: assert property (@(posedge clk) disable iff (rst)
        !fade_en |=> duty_out == $past(target_duty));

    // R3: no movement without a period strobe
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (fade_en && !period_tick) |=> $stable(duty_out));

    // R3: rate 0 moves on every strobe while away from target
    p_every_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (fade_en && period_tick && rate_sel == '0 && duty_out != target_duty)
        |=> duty_out != $past(duty_out));

    // R4: upward move is bounded by the gain step
    p_up_step_r4: assert property (@(posedge clk) disable iff (rst)
        (fade_en && duty_out < target_duty)
        |=> (duty_out >= $past(duty_out)) &&
            ({1'b0, duty_out} - {1'b0, $past(duty_out)} <= $past(step_cap)));

    // R5: downward move is bounded by the gain step
    p_down_step_r5: assert property (@(posedge clk) disable iff (rst)
        (fade_en && duty_out > target_duty)
        |=> (duty_out <= $past(duty_out)) &&
            ({1'b0, $past(duty_out)} - {1'b0, duty_out} <= $past(step_cap)));

    // R6: no overshoot in either direction
    p_no_overshoot_up_r6: assert property (@(posedge clk) disable iff (rst)
        (fade_en && duty_out <= target_duty) |=> duty_out <= $past(target_duty));

    p_no_overshoot_dn_r6: assert property (@(posedge clk) disable iff (rst)
        (fade_en && duty_out >= target_duty) |=> duty_out >= $past(target_duty));

endmodule

bind fade_engine fade_engine_chk #(
    .DUTY_BITS (DUTY_BITS),
    .RATE_BITS (RATE_BITS)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .fade_en     (fade_en),
    .gain_sel    (gain_sel),
    .rate_sel    (rate_sel),
    .period_tick (period_tick),
    .target_duty (target_duty),
    .duty_out    (duty_out)
);

// File: tb/fade_engine_tb_top.sv
module fade_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FULL       = 262143;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fade_en = 1'b0;
    logic        gain_sel = 1'b0;
    logic [2:0]  rate_sel = 3'd0;
    logic        period_tick = 1'b0;
    logic [17:0] target_duty = '0;
    logic [17:0] duty_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fade_engine dut_i (
        .clk         (clk),
        .rst         (rst),
        .fade_en     (fade_en),
        .gain_sel    (gain_sel),
        .rate_sel    (rate_sel),
        .period_tick (period_tick),
        .target_duty (target_duty),
        .duty_out    (duty_out)
    );

    function automatic int model_step(int cur, int tgt, bit g);
        int d;
        d = g ? cur / 8 : cur / 16;
        if (d == 0) d = 1;
        if (cur < tgt) return (cur + d > tgt) ? tgt : cur + d;
        if (cur > tgt) return (cur - d < tgt) ? tgt : cur - d;
        return cur;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) period_tick = 1'b1;
        @(negedge clk) period_tick = 1'b0;
    endtask

    // Load a duty value through the pass-through path (R2).
    task automatic load_duty(int v);
        @(negedge clk);
        fade_en     = 1'b0;
        period_tick = 1'b0;
        target_duty = 18'(v);
        @(negedge clk);
    endtask

    task automatic run_fade(int start, int tgt, bit g, string req);
        int cur;
        load_duty(start);
        fade_en     = 1'b1;
        gain_sel    = g;
        rate_sel    = 3'd0;
        target_duty = 18'(tgt);
        cur = start;
        for (int k = 0; k < 500 && cur != tgt; k++) begin
            pulse_tick();
            cur = model_step(cur, tgt, g);
            check(req, int'(duty_out), cur);
        end
        check(req, int'(duty_out), tgt);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(duty_out), 0);
        target_duty = 18'd5000;
        @(negedge clk) rst = 1'b0;
        check("R1", int'(duty_out), 0);

        // R2: pass-through sweep
        for (int i = 0; i < 16; i++) begin
            int v;
            v = (i * 17389 + 11) % (FULL + 1);
            load_duty(v);
            check("R2", int'(duty_out), v);
        end
        load_duty(FULL);
        check("R2", int'(duty_out), FULL);

        // R4, R7: upward from zero, fine gain
        run_fade(0, 200000, 1'b0, "R4/R7");
        // R4: upward, coarse gain
        run_fade(700, 150000, 1'b1, "R4");
        // R5: downward, both gains
        run_fade(FULL, 300, 1'b1, "R5");
        run_fade(90000, 5, 1'b0, "R5");
        // R6: clamp on a short hop in both directions
        run_fade(1000, 1010, 1'b1, "R6");
        run_fade(1000, 990, 1'b1, "R6");
        // R9: reach full scale and hold
        run_fade(1000, FULL, 1'b1, "R9");
        for (int k = 0; k < 4; k++) begin
            pulse_tick();
            check("R9", int'(duty_out), FULL);
        end

        // R3: no change without ticks
        load_duty(4000);
        fade_en     = 1'b1;
        gain_sel    = 1'b0;
        target_duty = 18'd100000;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R3", int'(duty_out), 4000);
        end

        // R3, R8: interval sweep over every rate code
        for (int r = 0; r < 8; r++) begin
            int n;
            n = 1 << ((r > 5) ? 5 : r);
            load_duty(1000);
            fade_en     = 1'b1;
            gain_sel    = 1'b0;
            rate_sel    = 3'(r);
            target_duty = 18'd100000;
            for (int k = 1; k <= n; k++) begin
                pulse_tick();
                check((r > 5) ? "R8" : "R3", int'(duty_out),
                      (k < n) ? 1000 : model_step(1000, 100000, 1'b0));
            end
            // second interval lands exactly one more step later
            for (int k = 1; k <= n; k++) pulse_tick();
            check((r > 5) ? "R8" : "R3", int'(duty_out),
                  model_step(model_step(1000, 100000, 1'b0), 100000, 1'b0));
        end

        // R2: disabling mid-fade forwards target at once
        load_duty(2000);
        fade_en     = 1'b1;
        rate_sel    = 3'd0;
        target_duty = 18'd60000;
        pulse_tick();
        @(negedge clk) fade_en = 1'b0;
        @(negedge clk);
        check("R2", int'(duty_out), 60000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule